// File: doc/BRIEF.md
# Rank Boundary Address Decoder

This block turns a physical memory address into the DRAM rank and channel that hold it. Software programs, through a byte-wide write port, four cumulative rank-top registers per channel and a set of page-size attribute bytes. Each rank-top value is measured in 32 MiB units. From these the block decides on its own whether the two channels are populated the same way. When they are, it treats them as one interleaved pair. When they are not, it treats them as one asymmetric channel, with channel 1 stacked above channel 0.

A lookup is presented with `lk_valid` and an address. One clock later the block returns whether a rank was hit or the address lies beyond populated memory. On a hit it also returns the channel, the rank index within that channel and the page-size code of that rank. The rank limits are compared in parallel and a priority encoder picks the lowest rank whose limit lies above the address. An empty rank repeats the previous limit, so it can never be chosen. `RANKS_PER_CH` must be a power of two.

Top module: `rank_bound_decoder`

## Requirements
- R1: A write with `cfg_we` high stores `cfg_wdata` at the clock edge into the register picked by `cfg_sel`. The selector values are: 0..3 for the channel 0 rank tops (rank 0..3), 4..7 for the channel 1 rank tops, 8..9 for the channel 0 attribute bytes (ranks 0/1, then 2/3), and 10..11 for the channel 1 attribute bytes.
- R2: A write to a selector of 12 or more changes no register, so both the decode and `interleaved` stay unchanged.
- R3: `interleaved` is 1 exactly when all four rank tops and all attribute fields are equal between the channels. In an attribute byte, bits 2:0 belong to the even rank and bits 6:4 to the odd rank. Bits 3 and 7 play no part in the comparison.
- R4: In interleaved mode the rank limits are the channel 0 rank tops multiplied by two. `res_channel` is address bit `CH_BIT` (default 6).
- R5: In asymmetric mode the channel 0 ranks come first. The channel 1 ranks follow, with limits equal to the channel 0 total plus the channel 1 rank tops, and they are reported with `res_channel` = 1.
- R6: The reported rank is the lowest index whose limit is strictly greater than the address divided by 32 MiB. A rank whose limit equals the limit below it is never reported.
- R7: When no limit lies above the address, `res_oor` is 1, and `res_hit`, `res_channel`, `res_rank` and `res_page` are 0.
- R8: On a hit, `res_page` is the 3-bit attribute field of the reported rank (000 unpopulated, 010 4 KB, 011 8 KB, 100 16 KB).
- R9: `res_valid` follows `lk_valid` by one clock. While `res_valid` is 0, all other result outputs are 0.
- R10: After reset all registers are zero, so `interleaved` is 1, every address is out of range, and all result outputs are 0.
- R11: A lookup and a write in the same cycle return the decode of the configuration as it stood before that write. `interleaved` shows the new configuration from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | SEL_W (4) | Configuration register selector |
| cfg_wdata | input | 8 | Configuration write data |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | ADDR_W (34) | Physical address to decode |
| res_valid | output | 1 | Result valid, one cycle after the request |
| res_hit | output | 1 | Address falls in a populated rank |
| res_oor | output | 1 | Address lies at or above populated memory |
| res_channel | output | 1 | Channel of the hit rank |
| res_rank | output | RK_W (2) | Rank index within the channel |
| res_page | output | 3 | Page-size attribute code of the hit rank |
| interleaved | output | 1 | Channels are populated identically |

## Verification
A configuration write and a lookup can fall in the same clock cycle. The write updates the registers at the same edge that captures the lookup result. The bench provokes this by writing a new channel 0 rank top while it requests an address whose bit 6 is set, in interleaved mode. Under the old configuration that address resolves to channel 1. Under the new, asymmetric configuration it resolves to channel 0. The result is judged correct only if it still shows channel 1. The bench then checks that `interleaved` has already dropped, and that a repeat of the lookup now returns channel 0.

// File: rtl/rbd_pkg.sv
package rbd_pkg;
    localparam int BND_W = 8;
    localparam int FLD_W = 3;
    localparam int NCH   = 2;

    // Extract the page-size field of one rank from its pair byte.
    function automatic logic [FLD_W-1:0] rank_field(input logic [BND_W-1:0] pair_byte,
                                                    input logic odd_rank);
        return odd_rank ? pair_byte[6:4] : pair_byte[2:0];
    endfunction
endpackage

// File: rtl/rbd_cfg_regs.sv
module rbd_cfg_regs import rbd_pkg::*; #(
    parameter  int RPC   = 4,
    localparam int NPAIR = RPC / 2,
    localparam int NREG  = NCH * RPC + NCH * NPAIR,
    localparam int SEL_W = $clog2(NREG + 1)
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 we,
    input  logic [SEL_W-1:0]                     sel,
    input  logic [BND_W-1:0]                     wdata,
    output logic [NCH-1:0][RPC-1:0][BND_W-1:0]   bnd,
    output logic [NCH-1:0][NPAIR-1:0][BND_W-1:0] attr
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bnd  <= '0;
            attr <= '0;
        end else if (we) begin
            for (int c = 0; c < NCH; c++) begin
                for (int r = 0; r < RPC; r++)
                    if (int'(sel) == c * RPC + r) bnd[c][r] <= wdata;
                for (int p = 0; p < NPAIR; p++)
                    if (int'(sel) == NCH * RPC + c * NPAIR + p) attr[c][p] <= wdata;
            end
        end
    end

    assert_first_bnd_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (we && sel == '0) |=> (bnd[0][0] == $past(wdata)));

    assert_unused_sel_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (we && int'(sel) >= NREG) |=> ($stable(bnd) && $stable(attr)));
endmodule

// File: rtl/rbd_ilv_detect.sv
module rbd_ilv_detect import rbd_pkg::*; #(
    parameter  int RPC   = 4,
    localparam int NPAIR = RPC / 2
) (
    input  logic [NCH-1:0][RPC-1:0][BND_W-1:0]   bnd,
    input  logic [NCH-1:0][NPAIR-1:0][BND_W-1:0] attr,
    output logic                                 ilv
);
    always_comb begin
        ilv = 1'b1;
        for (int r = 0; r < RPC; r++)
            if (bnd[0][r] != bnd[1][r]) ilv = 1'b0;
        for (int p = 0; p < NPAIR; p++) begin
            if (rank_field(attr[0][p], 1'b0) != rank_field(attr[1][p], 1'b0)) ilv = 1'b0;
            if (rank_field(attr[0][p], 1'b1) != rank_field(attr[1][p], 1'b1)) ilv = 1'b0;
        end
    end
endmodule

// File: rtl/rbd_rank_lookup.sv
module rbd_rank_lookup import rbd_pkg::*; #(
    parameter  int RPC    = 4,
    parameter  int CMP_W  = 9,
    localparam int NSLOT  = NCH * RPC,
    localparam int SLOT_W = $clog2(NSLOT)
) (
    input  logic [NCH-1:0][RPC-1:0][BND_W-1:0] bnd,
    input  logic                               ilv,
    input  logic [CMP_W-1:0]                   unit,
    output logic                               hit,
    output logic [SLOT_W-1:0]                  slot,
    output logic [CMP_W-1:0]                   top
);
    logic [NSLOT-1:0][CMP_W-1:0] lim;
    logic [NSLOT-1:0]            above;
    logic [CMP_W-1:0]            top0;

    assign top0 = ilv ? (CMP_W'(bnd[0][RPC-1]) << 1) : CMP_W'(bnd[0][RPC-1]);

    for (genvar r = 0; r < RPC; r++) begin : g_lim
        assign lim[r]       = ilv ? (CMP_W'(bnd[0][r]) << 1) : CMP_W'(bnd[0][r]);
        assign lim[RPC + r] = ilv ? top0 : top0 + CMP_W'(bnd[1][r]);
    end

    for (genvar s = 0; s < NSLOT; s++) begin : g_cmp
        assign above[s] = lim[s] > unit;
    end

    always_comb begin
        hit  = |above;
        slot = '0;
        for (int s = NSLOT - 1; s >= 0; s--)
            if (above[s]) slot = SLOT_W'(s);
    end

    assign top = lim[NSLOT-1];
endmodule

// File: rtl/rank_bound_decoder.sv
module rank_bound_decoder import rbd_pkg::*; #(
    parameter  int RANKS_PER_CH = 4,
    parameter  int ADDR_W       = 34,
    parameter  int UNIT_SHIFT   = 25,
    parameter  int CH_BIT       = 6,
    localparam int NPAIR        = RANKS_PER_CH / 2,
    localparam int NREG         = NCH * RANKS_PER_CH + NCH * NPAIR,
    localparam int SEL_W        = $clog2(NREG + 1),
    localparam int RK_W         = $clog2(RANKS_PER_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [BND_W-1:0]  cfg_wdata,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              res_valid,
    output logic              res_hit,
    output logic              res_oor,
    output logic              res_channel,
    output logic [RK_W-1:0]   res_rank,
    output logic [FLD_W-1:0]  res_page,
    output logic              interleaved
);
    localparam int UNIT_W = ADDR_W - UNIT_SHIFT;
    localparam int LIM_W  = BND_W + 1;
    localparam int CMP_W  = (UNIT_W > LIM_W) ? UNIT_W : LIM_W;
    localparam int SLOT_W = $clog2(NCH * RANKS_PER_CH);

    logic [NCH-1:0][RANKS_PER_CH-1:0][BND_W-1:0] bnd;
    logic [NCH-1:0][NPAIR-1:0][BND_W-1:0]        attr;
    logic [CMP_W-1:0]  unit, top;
    logic              hit;
    logic [SLOT_W-1:0] slot;
    logic              d_ch;
    logic [RK_W-1:0]   d_rank;
    logic [FLD_W-1:0]  d_page;

    rbd_cfg_regs #(.RPC(RANKS_PER_CH)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel),
        .wdata(cfg_wdata), .bnd(bnd), .attr(attr)
    );

    rbd_ilv_detect #(.RPC(RANKS_PER_CH)) u_ilv (
        .bnd(bnd), .attr(attr), .ilv(interleaved)
    );

    assign unit = CMP_W'(lk_addr[ADDR_W-1:UNIT_SHIFT]);

    rbd_rank_lookup #(.RPC(RANKS_PER_CH), .CMP_W(CMP_W)) u_look (
        .bnd(bnd), .ilv(interleaved), .unit(unit),
        .hit(hit), .slot(slot), .top(top)
    );

    always_comb begin
        d_ch   = 1'b0;
        d_rank = '0;
        d_page = '0;
        if (hit) begin
            d_rank = slot[RK_W-1:0];
            d_ch   = interleaved ? lk_addr[CH_BIT] : slot[SLOT_W-1];
            d_page = rank_field(attr[d_ch][int'(d_rank) / 2], d_rank[0]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_valid   <= 1'b0;
            res_hit     <= 1'b0;
            res_oor     <= 1'b0;
            res_channel <= 1'b0;
            res_rank    <= '0;
            res_page    <= '0;
        end else begin
            res_valid   <= lk_valid;
            res_hit     <= lk_valid & hit;
            res_oor     <= lk_valid & ~hit;
            res_channel <= lk_valid & d_ch;
            res_rank    <= lk_valid ? d_rank : '0;
            res_page    <= lk_valid ? d_page : '0;
        end
    end

    assert_result_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> res_valid);

    assert_no_result_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !res_valid);

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> (!res_hit && !res_oor && !res_channel && res_rank == '0 && res_page == '0));

    assert_beyond_top_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && unit >= top) |=> (res_oor && !res_hit && res_page == '0));

    assert_ilv_channel_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && interleaved && unit < top) |=> (res_hit && res_channel == $past(lk_addr[CH_BIT])));
endmodule

// File: tb/rank_bound_decoder_tb.sv
`timescale 1ns/1ps
module rank_bound_decoder_tb_top;
    localparam int AW = 34;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [3:0] cfg_sel = '0;
    logic [7:0] cfg_wdata = '0;
    logic lk_valid = 1'b0;
    logic [AW-1:0] lk_addr = '0;
    logic res_valid, res_hit, res_oor, res_channel, interleaved;
    logic [1:0] res_rank;
    logic [2:0] res_page;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    rank_bound_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .lk_valid(lk_valid), .lk_addr(lk_addr),
        .res_valid(res_valid), .res_hit(res_hit), .res_oor(res_oor),
        .res_channel(res_channel), .res_rank(res_rank), .res_page(res_page),
        .interleaved(interleaved)
    );

    // vector: {cfg, addr[33:0], hit, oor, ch, rank[1:0], page[2:0]}
    function automatic logic [42:0] mk(input bit cfg, input longint unit, input longint low,
                                       input bit hit, input bit oor, input bit ch,
                                       input int rank, input int page);
        logic [AW-1:0] a;
        a = AW'((unit << 25) | low);
        return {cfg, a, hit, oor, ch, 2'(rank), 3'(page)};
    endfunction

    // Config 0 asymmetric: limits 4,4,12,12 then 20 x4 (R5 R6 R7 R8, map per R1)
    // Config 1 interleaved: limits 4,12,12,20 (R4 R6 R7 R8)
    localparam logic [42:0] TBL [16] = '{
        mk(0,   0, 0,          1,0,0,0,2),
        mk(0,   3, 'h1FFFFFF,  1,0,0,0,2),
        mk(0,   4, 0,          1,0,0,2,3),
        mk(0,  11, 'h40,       1,0,0,2,3),
        mk(0,  12, 0,          1,0,1,0,4),
        mk(0,  19, 'h1FFFFFF,  1,0,1,0,4),
        mk(0,  20, 0,          0,1,0,0,0),
        mk(0, 511, 'h1FFFFFF,  0,1,0,0,0),
        mk(1,   0, 0,          1,0,0,0,2),
        mk(1,   0, 'h40,       1,0,1,0,2),
        mk(1,   4, 0,          1,0,0,1,3),
        mk(1,  11, 'h40,       1,0,1,1,3),
        mk(1,  12, 0,          1,0,0,3,4),
        mk(1,  19, 'h40,       1,0,1,3,4),
        mk(1,  20, 0,          0,1,0,0,0),
        mk(1,  40, 0,          0,1,0,0,0)
    };

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input int sel, input int data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 4'(sel); cfg_wdata = 8'(data);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic look(input logic [AW-1:0] a);
        @(negedge clk);
        lk_valid = 1'b1; lk_addr = a;
        @(negedge clk);
        lk_valid = 1'b0;
    endtask

    task automatic load_cfg(input bit which);
        if (!which) begin
            wr(0, 4); wr(1, 4); wr(2, 12); wr(3, 12);
            wr(4, 8); wr(5, 8); wr(6, 8);  wr(7, 8);
            wr(8, 'h02); wr(9, 'h03); wr(10, 'h04); wr(11, 'h00);
        end else begin
            wr(0, 2); wr(1, 6); wr(2, 6); wr(3, 10);
            wr(4, 2); wr(5, 6); wr(6, 6); wr(7, 10);
            wr(8, 'h32); wr(9, 'h40); wr(10, 'hB2); wr(11, 'h48);
        end
    endtask

    function automatic logic [7:0] got();
        return {res_hit, res_oor, res_channel, res_rank, res_page};
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        bit cur;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk({res_valid, got()} == 9'h0, "R10 outputs after reset", {res_valid, got()}, 0);
        chk(interleaved == 1'b1, "R10 interleaved after reset", interleaved, 1);
        look('0);
        chk(res_valid && got() == 8'h40, "R10 R7 empty config is out of range", got(), 8'h40);
        // R9 idle cycle
        @(negedge clk);
        chk(!res_valid && got() == 8'h0, "R9 no request gives quiet outputs", {res_valid, got()}, 0);

        // Table walk (R1 R4 R5 R6 R7 R8)
        cur = 1'b0;
        load_cfg(1'b0);
        chk(interleaved == 1'b0, "R3 differing channels are asymmetric", interleaved, 0);
        for (int i = 0; i < 16; i++) begin
            if (TBL[i][42] != cur) begin
                cur = TBL[i][42];
                load_cfg(cur);
                chk(interleaved == cur, "R3 reserved bits ignored, interleave detect", interleaved, cur);
            end
            look(TBL[i][41:8]);
            chk(res_valid && got() == TBL[i][7:0],
                $sformatf("R1 R4 R5 R6 R7 R8 table row %0d", i), got(), TBL[i][7:0]);
        end

        // R3: boundary mismatch breaks interleave, then attribute mismatch
        wr(7, 11);
        chk(interleaved == 1'b0, "R3 boundary mismatch", interleaved, 0);
        wr(7, 10);
        chk(interleaved == 1'b1, "R3 boundary restored", interleaved, 1);
        wr(10, 'h33);
        chk(interleaved == 1'b0, "R3 even field mismatch", interleaved, 0);
        wr(10, 'hB2);
        chk(interleaved == 1'b1, "R3 attribute restored", interleaved, 1);

        // R2: unused selectors change nothing
        for (int s = 12; s < 16; s++) wr(s, 'hFF);
        chk(interleaved == 1'b1, "R2 unused selector kept interleave", interleaved, 1);
        look(TBL[13][41:8]);
        chk(got() == TBL[13][7:0], "R2 unused selector kept decode", got(), TBL[13][7:0]);

        // R11: write and lookup in the same cycle
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 4'd0; cfg_wdata = 8'd10;
        lk_valid = 1'b1; lk_addr = AW'('h40);
        @(negedge clk);
        cfg_we = 1'b0; lk_valid = 1'b0;
        chk(res_valid && got() == 8'hA2, "R11 same-cycle lookup uses old config", got(), 8'hA2);
        chk(interleaved == 1'b0, "R11 new config visible after write", interleaved, 0);
        look(AW'('h40));
        chk(got() == 8'h82, "R11 follow-up lookup uses new config", got(), 8'h82);
        wr(0, 2);
        chk(interleaved == 1'b1, "R1 rank top rewrite restores interleave", interleaved, 1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule